// File: doc/BRIEF.md
# Processor-side program ROM and work RAM decoder

This block decodes the processor bus of a cartridge memory controller. Any access to the upper 32 KB of processor space selects program ROM. The block can also switch that ROM between two 32 KB banks. The bank is not chosen by a processor register write. It is taken from two bits of the picture-processor address bus. A change there is latched on the system clock, so the bank bit holds steady while the processor runs its bus cycle. No read on the picture-processor side is needed to change the bank.

An optional work RAM of 4 KB or 8 KB appears in two main windows, `$5xxx` and `$7xxx`. Each main window has a mirror window, `$1xxx` and `$3xxx`. Writes through a mirror reach the RAM normally. A read through a mirror drives the data bus while another device may drive it too, so the block raises a warning flag for such reads. All enables are qualified with the processor's M2 phase. With the 4 KB size both windows reach the same RAM. With the 8 KB size, processor address bit 13 chooses the upper or lower half.

There is no data stream in this block. Every pin is a plain control or address line, with no handshake. Inputs are sampled every cycle.

Top module: `prg_bus_decoder`

## Requirements
- R1: `rom_en` is 1 exactly when `cpu_m2` is 1 and `cpu_addr[15]` is 1 (`$8000-$FFFF`). Otherwise it is 0.
- R2: With `RAM_PRESENT`=1, `ram_en` is 1 exactly when `cpu_m2` is 1, `cpu_addr[15]` is 0 and `cpu_addr[12]` is 1. These are the windows `$1xxx`, `$3xxx`, `$5xxx` and `$7xxx`. With `RAM_PRESENT`=0, `ram_en` is always 0.
- R3: `ram_we` is 1 exactly when `ram_en` is 1 and `cpu_rw` is 0. `cpu_rw` is 1 for a read and 0 for a write.
- R4: `ram_addr[11:0]` equals `cpu_addr[11:0]`. With `RAM_KB`=8, `ram_addr` is 13 bits wide and `ram_addr[12]` equals `cpu_addr[13]`. With `RAM_KB`=4 it is 12 bits wide.
- R5: `bus_conflict` is 1 exactly when `ram_en` is 1, `cpu_rw` is 1 and `cpu_addr[14]` is 0. These are reads through the mirror windows `$1xxx` and `$3xxx`. Writes through a mirror never raise the flag.
- R6: With `BANK_SWITCH`=1, `rom_bank` at each clock edge takes the value `pic_a13 & pic_a12` sampled at that edge. It is therefore due one clock after the inputs change. With `BANK_SWITCH`=0 it stays 0.
- R7: While `rst_n` is 0, `rom_bank` is 0 (bank 0).
- R8: `rom_en` and `ram_en` are never 1 together. The processor windows `$0xxx`, `$2xxx`, `$4xxx` and `$6xxx` assert neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | Processor M2 phase; enables are active only while it is high |
| pic_a13 | input | 1 | Picture-processor address bit 13 |
| pic_a12 | input | 1 | Picture-processor address bit 12 |
| rom_en | output | 1 | Program ROM select |
| rom_bank | output | 1 | Program ROM 32 KB bank bit, registered |
| ram_en | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write strobe |
| ram_addr | output | RAM_AW | Work RAM address (12 or 13 bits) |
| bus_conflict | output | 1 | A read through a mirror window is in progress |

## Verification
The enables, the RAM address and the conflict flag all follow the inputs in the same cycle. The bench checks them a short settle delay after it drives each new input set, well clear of any clock edge. The bank bit is the only registered result, due one clock edge after the picture-processor bits change. The bench drives inputs just after a falling edge and checks the bank at the next falling edge against the value it drove one edge earlier. The stimulus mixes random addresses, reads, writes and M2 phases with directed window-boundary addresses and mirror reads and writes.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;
  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_ROM    = 2'd1,
    WIN_RAM    = 2'd2,
    WIN_MIRROR = 2'd3
  } win_kind_t;

  function automatic int ram_width(input int kb);
    return (kb == 8) ? 13 : 12;
  endfunction
endpackage

// File: rtl/prg_window_dec.sv
module prg_window_dec
  import prg_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output win_kind_t         kind
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    if (addr[TOP])
      kind = WIN_ROM;
    else if (addr[12])
      kind = addr[14] ? WIN_RAM : WIN_MIRROR;
    else
      kind = WIN_NONE;
  end
endmodule

// File: rtl/prg_bank_reg.sv
module prg_bank_reg #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a13,
  input  logic a12,
  output logic bank
);
  generate
    if (ENABLE) begin : g_sw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank <= 1'b0;
        else        bank <= a13 & a12;
      end
      AST_BANK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bank == $past(a13 && a12))); // R6
    end else begin : g_fixed
      assign bank = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prg_ram_map.sv
module prg_ram_map #(
  parameter int RAM_KB = 8,
  parameter int AW     = 13
) (
  input  logic [15:0]   addr,
  output logic [AW-1:0] ram_addr
);
  generate
    if (RAM_KB == 8) begin : g_8k
      assign ram_addr = {addr[13], addr[11:0]};
    end else begin : g_4k
      assign ram_addr = addr[AW-1:0];
    end
  endgenerate

  always_comb begin
    AST_LOW_BITS: assert (ram_addr[11:0] == addr[11:0]); // R4
  end
endmodule

// File: rtl/prg_bus_decoder.sv
module prg_bus_decoder
  import prg_dec_pkg::*;
#(
  parameter int RAM_KB      = 8,
  parameter bit RAM_PRESENT = 1'b1,
  parameter bit BANK_SWITCH = 1'b1,
  localparam int RAM_AW     = ram_width(RAM_KB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic              pic_a13,
  input  logic              pic_a12,
  output logic              rom_en,
  output logic              rom_bank,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              bus_conflict
);
  win_kind_t kind;
  logic      ram_hit;
  logic      mirror_hit;

  prg_window_dec #(.ADDR_W(16)) u_win (.addr(cpu_addr), .kind(kind));

  prg_bank_reg #(.ENABLE(BANK_SWITCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .a13(pic_a13), .a12(pic_a12), .bank(rom_bank));

  prg_ram_map #(.RAM_KB(RAM_KB), .AW(RAM_AW)) u_map (
    .addr(cpu_addr), .ram_addr(ram_addr));

  assign mirror_hit = (kind == WIN_MIRROR);
  assign ram_hit    = RAM_PRESENT && ((kind == WIN_RAM) || mirror_hit);

  always_comb begin
    rom_en       = cpu_m2 && (kind == WIN_ROM);
    ram_en       = cpu_m2 && ram_hit;
    ram_we       = ram_en && !cpu_rw;
    bus_conflict = ram_en && cpu_rw && mirror_hit;
  end

  AST_EN_EXCL:    assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_en && ram_en)); // R8
  AST_M2_GATE:    assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_m2 |-> !(rom_en || ram_en || ram_we)); // R1
  AST_WE_IN_RAM:  assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_en && !cpu_addr[15])); // R3
  AST_CONF_READ:  assert property (@(posedge clk) disable iff (!rst_n)
    bus_conflict |-> (cpu_rw && !cpu_addr[14] && cpu_addr[12] && ram_en)); // R5
  AST_RESET_BANK: assert property (@(posedge clk)
    !rst_n |-> !rom_bank); // R7
endmodule

// File: tb/prg_bus_decoder_bench.sv
`timescale 1ns/1ps
module prg_bus_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rw = 1'b1, cpu_m2 = 1'b0, pic_a13 = 1'b0, pic_a12 = 1'b0;
  logic rom_en, rom_bank, ram_en, ram_we, bus_conflict;
  logic [12:0] ram_addr;
  int total = 0, bad = 0;
  logic prev_bank;

  always #10 clk = ~clk;

  prg_bus_decoder u_prg_bus_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .pic_a13(pic_a13), .pic_a12(pic_a12),
    .rom_en(rom_en), .rom_bank(rom_bank), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .bus_conflict(bus_conflict));

  function automatic logic f_rom(input logic [15:0] a, input logic m2);
    return m2 & a[15];
  endfunction
  function automatic logic f_ram(input logic [15:0] a, input logic m2);
    return m2 & ~a[15] & a[12];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, cpu_addr);
    end
  endtask

  task automatic check_comb();
    logic er;
    er = f_ram(cpu_addr, cpu_m2);
    chk("R1", rom_en, f_rom(cpu_addr, cpu_m2));
    chk("R2", ram_en, er);
    chk("R3", ram_we, er & ~cpu_rw);
    chk("R4", ram_addr, {cpu_addr[13], cpu_addr[11:0]});
    chk("R5", bus_conflict, er & cpu_rw & ~cpu_addr[14]);
    if (cpu_addr[12] == 1'b0 && cpu_addr[15] == 1'b0)
      chk("R8", rom_en | ram_en, 1'b0);
  endtask

  task automatic step(input logic [15:0] a, input logic rw, input logic m2,
                      input logic p13, input logic p12);
    @(negedge clk);
    chk("R6", rom_bank, prev_bank);
    cpu_addr = a; cpu_rw = rw; cpu_m2 = m2; pic_a13 = p13; pic_a12 = p12;
    #2;
    check_comb();
    prev_bank = p13 & p12;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] dir [12];
    void'($urandom(32'h5EED_0042));
    pic_a13 = 1'b1; pic_a12 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", rom_bank, 1'b0);
    pic_a13 = 1'b0; pic_a12 = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    prev_bank = 1'b0;
    dir = '{16'h4FFF, 16'h5000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000,
            16'hFFFF, 16'h0FFF, 16'h1000, 16'h3FFF, 16'h2000, 16'h7123};
    foreach (dir[i]) begin
      step(dir[i], 1'b1, 1'b1, 1'b0, 1'b0);
      step(dir[i], 1'b0, 1'b1, 1'b1, 1'b0);
      step(dir[i], 1'b1, 1'b0, 1'b0, 1'b1);
    end
    // R5: mirror write never flags, mirror read does
    step(16'h1234, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5", bus_conflict, 1'b0);
    step(16'h3234, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R5", bus_conflict, 1'b1);
    // R6: bank needs both bits; held across steps
    step(16'h8000, 1'b1, 1'b1, 1'b1, 1'b1);
    step(16'h8000, 1'b1, 1'b1, 1'b1, 1'b1);
    step(16'h8000, 1'b1, 1'b1, 1'b0, 1'b1);
    step(16'h8000, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 3000; k++)
      step(16'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0),
           1'($urandom), 1'($urandom));
    @(negedge clk);
    chk("R6", rom_bank, prev_bank);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule